// File: doc/BRIEF.md
# Code-Group Serializer with Wrap Path

This block takes code groups that are already line-encoded, CG_W bits wide (ten by default), from a parallel bus and emits them one bit at a time. The whole block runs on a single clock. A bit-rate enable, `bit_ce`, marks each bit period. Every CG_W bit periods the block takes a new group from `cg_data`, and it pulses `cg_take` in the cycle whose clock edge does the capture. That pulse is the code-group clock as seen by the upstream encoder. Groups follow one another with no idle bit between them, and the least significant bit of each group goes out first.

Two controls steer the stream. `wrap_en` diverts the serial stream onto `loop_bit`, which feeds a receive path for self-test, and holds the line value at logic 1. With `wrap_en` low, the stream goes to the line and `loop_bit` rests at 1. `out_en` drives `line_oe`, the tri-state enable of the line pad. When it is low, the pad floats. When it is high, the pad carries `line_q`. For normal traffic `wrap_en` is tied low and `out_en` high.

Top module: `cgser_top`

## Requirements
- R1: A synchronous reset loads the shift register with all ones and sets the slot counter so that the first `bit_ce` after reset captures a group. With reset released and no capture yet, the serial value is 1.
- R2: `cg_take` is high only in a cycle with `bit_ce` high, and exactly once in every CG_W (10) consecutive `bit_ce` pulses, counting from the first pulse after reset.
- R3: In the cycle after a capture edge, the serial value is bit 0 of the captured `cg_data`. After the k-th following `bit_ce` (k = 1..9), it is bit k. The latency from capture to the first serial bit is therefore zero bit periods.
- R4: The next group is captured on the `bit_ce` right after bit 9 of the current group has been shown, so no idle bits appear between groups.
- R5: `line_oe` equals `out_en` in every cycle, combinationally (1 = driven, 0 = high impedance).
- R6: With `wrap_en` = 1, `line_q` is 1 and `loop_bit` carries the serial value.
- R7: With `wrap_en` = 0, `line_q` carries the serial value and `loop_bit` is 1.
- R8: In a cycle with `bit_ce` low, the serial value and the slot position do not change at the next edge, and `cg_take` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_ce | input | 1 | Bit-period enable |
| cg_data | input | CG_W | Encoded code group, sampled when `cg_take` is high |
| out_en | input | 1 | Line output enable |
| wrap_en | input | 1 | Loopback (wrap) select |
| cg_take | output | 1 | High in the cycle whose edge captures `cg_data` |
| line_q | output | 1 | Line serial value |
| line_oe | output | 1 | Line pad drive enable |
| loop_bit | output | 1 | Loopback serial value toward the receive path |

## Verification
`cg_take`, `line_oe` and the routing onto `line_q` and `loop_bit` respond in the same cycle as their inputs. The serial value, however, changes only one clock after a `bit_ce` edge. For that reason the bench drives its inputs just after the falling edge and waits a short settle time before comparing. It checks the combinational outputs against the inputs it has just applied, and it checks the serial value against a model that has been advanced only by the edges already taken. The model moves forward after each comparison, using the inputs that the coming rising edge will sample. This keeps every expected value aligned to the edge that produces it: zero bit periods from capture to bit 0, then one bit per enabled edge.

// File: rtl/cgser_pkg.sv
package cgser_pkg;

    typedef enum logic {
        PATH_LINE = 1'b0,
        PATH_WRAP = 1'b1
    } path_e;

    typedef struct packed {
        logic line_val;
        logic loop_val;
    } lane_t;

    // Idle level used on whichever lane is not carrying data
    localparam logic IDLE_LVL = 1'b1;

    function automatic path_e path_of(input logic wrap);
        return wrap ? PATH_WRAP : PATH_LINE;
    endfunction

    function automatic lane_t route_bit(input path_e p, input logic s);
        lane_t r;
        if (p == PATH_WRAP) begin
            r.line_val = IDLE_LVL;
            r.loop_val = s;
        end else begin
            r.line_val = s;
            r.loop_val = IDLE_LVL;
        end
        return r;
    endfunction

endpackage

// File: rtl/cgser_slot_ctr.sv
module cgser_slot_ctr #(
    parameter int CG_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_ce,
    output logic load_now
);
    localparam int IW = (CG_W > 1) ? $clog2(CG_W) : 1;
    localparam logic [IW-1:0] LAST = IW'(CG_W - 1);

    logic [IW-1:0] slot;

    assign load_now = bit_ce && (slot == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= LAST;
        end else if (bit_ce) begin
            slot <= (slot == LAST) ? '0 : slot + IW'(1);
        end
    end

    // R8: slot position frozen without a bit enable
    a_r8_slot_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_ce |=> $stable(slot));

    // R2: slot index never leaves its range
    a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
        slot <= LAST);
endmodule

// File: rtl/cgser_shifter.sv
module cgser_shifter #(
    parameter int CG_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_ce,
    input  logic            load,
    input  logic [CG_W-1:0] data,
    output logic            ser
);
    logic [CG_W-1:0] sr;

    assign ser = sr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '1;
        end else if (bit_ce) begin
            if (load) sr <= data;
            else      sr <= {1'b1, sr[CG_W-1:1]};
        end
    end

    // R8: register frozen without a bit enable
    a_r8_sr_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_ce |=> $stable(sr));

    // R3: bit k+1 moves down to the output position on each shift
    a_r3_shift_order: assert property (@(posedge clk) disable iff (rst)
        (bit_ce && !load) |=> ser == $past(sr[1]));
endmodule

// File: rtl/cgser_router.sv
module cgser_router
    import cgser_pkg::*;
(
    input  logic wrap_en,
    input  logic out_en,
    input  logic ser,
    output logic line_q,
    output logic line_oe,
    output logic loop_bit
);
    lane_t lanes;

    always_comb begin
        lanes    = route_bit(path_of(wrap_en), ser);
        line_q   = lanes.line_val;
        loop_bit = lanes.loop_val;
        line_oe  = out_en;
    end
endmodule

// File: rtl/cgser_top.sv
module cgser_top #(
    parameter int CG_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_ce,
    input  logic [CG_W-1:0] cg_data,
    input  logic            out_en,
    input  logic            wrap_en,
    output logic            cg_take,
    output logic            line_q,
    output logic            line_oe,
    output logic            loop_bit
);
    logic ser;

    cgser_slot_ctr #(.CG_W(CG_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .bit_ce   (bit_ce),
        .load_now (cg_take)
    );

    cgser_shifter #(.CG_W(CG_W)) u_sh (
        .clk    (clk),
        .rst    (rst),
        .bit_ce (bit_ce),
        .load   (cg_take),
        .data   (cg_data),
        .ser    (ser)
    );

    cgser_router u_rt (
        .wrap_en  (wrap_en),
        .out_en   (out_en),
        .ser      (ser),
        .line_q   (line_q),
        .line_oe  (line_oe),
        .loop_bit (loop_bit)
    );

    // R2: captures only happen on a bit enable
    a_r2_take_on_ce: assert property (@(posedge clk) disable iff (rst)
        cg_take |-> bit_ce);

    // R4: captures are never on adjacent enable cycles
    a_r4_take_spacing: assert property (@(posedge clk) disable iff (rst)
        cg_take |=> !cg_take);

    // R3: bit 0 of the captured group appears after the capture edge
    a_r3_first_bit: assert property (@(posedge clk) disable iff (rst)
        cg_take |=> ser == $past(cg_data[0]));

    // R6: wrap holds the line high
    a_r6_wrap_line: assert property (@(posedge clk) disable iff (rst)
        wrap_en |-> (line_q && loop_bit == ser));

    // R7: normal mode rests the loopback lane
    a_r7_line_path: assert property (@(posedge clk) disable iff (rst)
        !wrap_en |-> (loop_bit && line_q == ser));
endmodule

// File: tb/cgser_top_tb.sv
module cgser_top_tb;
    localparam int CG_W = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bit_ce = 1'b0;
    logic [CG_W-1:0] cg_data = '0;
    logic            out_en = 1'b1;
    logic            wrap_en = 1'b0;
    logic            cg_take, line_q, line_oe, loop_bit;

    int checks = 0;
    int failures = 0;

    logic [CG_W-1:0] m_sr;
    int              m_idx;

    always #4 clk = ~clk;

    cgser_top #(.CG_W(CG_W)) u_dut (
        .clk(clk), .rst(rst), .bit_ce(bit_ce), .cg_data(cg_data),
        .out_en(out_en), .wrap_en(wrap_en), .cg_take(cg_take),
        .line_q(line_q), .line_oe(line_oe), .loop_bit(loop_bit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_line(input logic s, input logic w);
        return w ? 1'b1 : s;
    endfunction

    function automatic logic exp_loop(input logic s, input logic w);
        return w ? s : 1'b1;
    endfunction

    // Drive one cycle, check against the model, then advance the model
    task automatic step(input logic ce, input logic [CG_W-1:0] d,
                        input logic oe, input logic wr);
        logic et;
        @(negedge clk);
        bit_ce = ce; cg_data = d; out_en = oe; wrap_en = wr;
        #1;
        et = ce && (m_idx == CG_W - 1);
        chk("R2/R4 cg_take", cg_take, et);
        chk("R5 line_oe", line_oe, oe);
        if (wr) begin
            chk("R6/R3 line_q", line_q, 1'b1);
            chk("R6/R3 loop_bit", loop_bit, exp_loop(m_sr[0], wr));
        end else begin
            chk("R7/R3 line_q", line_q, exp_line(m_sr[0], wr));
            chk("R7/R3 loop_bit", loop_bit, 1'b1);
        end
        if (ce) begin
            if (m_idx == CG_W - 1) begin
                m_sr  = d;
                m_idx = 0;
            end else begin
                m_sr  = {1'b1, m_sr[CG_W-1:1]};
                m_idx++;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_ce = 1'b1; cg_data = 10'h000;
        repeat (3) @(negedge clk);
        rst = 1'b0; bit_ce = 1'b0; wrap_en = 1'b1;
        m_sr = '1; m_idx = CG_W - 1;
        #1;
        chk("R1 idle loop_bit", loop_bit, 1'b1);
        chk("R1 cg_take idle", cg_take, 1'b0);
        wrap_en = 1'b0;
        #1;
        chk("R1 idle line_q", line_q, 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R1: many idle cycles without enable keep output at 1
        for (int i = 0; i < 5; i++) step(1'b0, 10'h000, 1'b1, 1'b0);

        // R3/R4: back-to-back groups at full rate, comma-like and alternating
        step(1'b1, 10'b0101111100, 1'b1, 1'b0);
        for (int i = 0; i < 9; i++) step(1'b1, 10'h3FF, 1'b1, 1'b0);
        step(1'b1, 10'h155, 1'b1, 1'b1);
        for (int i = 0; i < 9; i++) step(1'b1, 10'h000, 1'b1, 1'b1);

        // R3: zero-latency first bit, explicit
        step(1'b1, 10'h3FE, 1'b1, 1'b1);
        chk("R3 capture seen", cg_take, 1'b1);
        @(negedge clk); bit_ce = 1'b0; #1;
        chk("R3 first bit latency", loop_bit, 1'b0);
        for (int i = 0; i < 9; i++) step(1'b1, 10'h000, 1'b1, 1'b1);

        // R8: long enable gap mid-group holds the bit
        step(1'b1, 10'h2AA, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b0, 10'h0F0, 1'b1, 1'b0);

        // R5: output enable low
        for (int i = 0; i < 6; i++) step(1'b1, 10'h1C3, 1'b0, 1'b0);

        // Random traffic
        for (int i = 0; i < 4000; i++)
            step(($urandom % 10) < 7, CG_W'($urandom), ($urandom % 8) != 0,
                 ($urandom % 4) == 0);

        // R1: reset in the middle of traffic
        do_reset();
        for (int i = 0; i < 300; i++)
            step(($urandom % 2) == 0, CG_W'($urandom), 1'b1, ($urandom % 2) == 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule